// File: doc/BRIEF.md
# Dual-Port Bidirectional Bus Shift Register

This block is an eight-stage register that sits between two parallel buses, called port A and port B, and also has a serial input and a serial output. A direction control decides which bus supplies data and which bus receives the stored word. Data can be copied from one bus to the other in either direction. It can also be assembled bit by bit from the serial input and then shown on a bus, held in place, or taken from a bus and shifted out serially. Port A has its own enable, so several of these registers can share one A bus without driving it at the same time.

Each bus pin is split into an input vector, an output vector and an output-enable flag, so that the chip-level pad logic can build the tri-state drivers. A parallel load can happen on the rising clock edge, or it can be level-sensitive. In the level-sensitive case the stored word follows the source bus for as long as that mode is selected. Serial shifting always happens on the clock edge, whatever the asynchronous-select input says. Reset is synchronous and active high.

Top module: `duplex_bus_shreg`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, every stage becomes 0. After that edge the receiving port shows 0x00 and `ser_out` is 0, unless a level-sensitive load is active.
- R2: `b_oe` equals `dir_a2b`, and `a_oe` equals `!dir_a2b && a_en`. The two enables are never 1 together. With `dir_a2b`=1, A is the source bus and B receives. With `dir_a2b`=0, B is the source and A receives.
- R3: While `a_en` is 0, `a_oe` is 0 and `a_out` is 0x00, whatever the other controls are.
- R4: With `par_mode`=1, `async_load`=0, `dir_a2b`=1 and `a_en`=1, the stages take `a_in` at the rising clock edge.
- R5: With `par_mode`=1, `async_load`=0 and `dir_a2b`=0, the stages take `b_in` at the rising clock edge, whatever `a_en` is.
- R6: With `par_mode`=1, `async_load`=1 and a usable source bus, the stored word seen on the receiving port and on `ser_out` follows the source bus with no clock edge. When the mode ends, the stages keep the source value that was present at the last rising edge inside the mode.
- R7: With `par_mode`=0, each rising edge moves the stages one place: stage k+1 takes stage k, stage 0 takes `ser_in`, and `ser_out` is stage 7 (the MSB). `async_load` has no effect in this mode.
- R8: With `par_mode`=1, `dir_a2b`=1 and `a_en`=0, no load takes place, in either clocked or level-sensitive form. The stages keep their contents.
- R9: A port whose enable is 1 shows the stored word on its output vector. A port whose enable is 0 shows 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Permits port A to be sampled or driven |
| dir_a2b | input | 1 | 1: A is the source bus and B receives; 0: B is the source bus and A receives |
| par_mode | input | 1 | 1: parallel load; 0: serial shift |
| async_load | input | 1 | In parallel mode, 1 selects a level-sensitive load |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | 8 | Port A pin values seen by the block |
| a_out | output | 8 | Value to drive onto port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | 8 | Port B pin values seen by the block |
| b_out | output | 8 | Value to drive onto port B |
| b_oe | output | 1 | Drive enable for port B |
| ser_out | output | 1 | Serial output, stage 7 |

## Verification
Some properties are checked on every clock by assertions:
- the two port enables are never on together;
- a serial shift moves the stages by exactly one place;
- a parallel load with port A disabled leaves the stages unchanged;
- a clocked load from A stores `a_in`;
- in level-sensitive mode from B, `a_out` follows `b_in`.

Other behaviour only the bench scenarios can show:
- the mid-cycle following of the source bus with no edge in between;
- the value kept after the level-sensitive mode ends;
- reset clearing a loaded word;
- clocked loads from B;
- a sweep through all sixteen combinations of the four mode controls with distinct data.

// File: rtl/duplex_bus_shreg_pkg.sv
package duplex_bus_shreg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD     = 2'd0,
        OP_SHIFT    = 2'd1,
        OP_LOAD_CLK = 2'd2,
        OP_LOAD_LVL = 2'd3
    } op_e;

    // Serial mode wins over the asynchronous select; an unusable source bus
    // turns any parallel request into a hold.
    function automatic op_e pick_op(input logic par, input logic lvl, input logic src_ok);
        if (!par)   return OP_SHIFT;
        if (!src_ok) return OP_HOLD;
        return lvl ? OP_LOAD_LVL : OP_LOAD_CLK;
    endfunction

endpackage

// File: rtl/bus_ctl_decode.sv
module bus_ctl_decode
    import duplex_bus_shreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         par_mode,
    input  logic         async_load,
    input  logic         dir_a2b,
    input  logic         a_en,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output op_e          op,
    output logic [W-1:0] src,
    output logic         a_drive,
    output logic         b_drive
);
    logic src_ok;

    // A may only be sampled while enabled; B is always usable.
    assign src_ok  = dir_a2b ? a_en : 1'b1;
    assign src     = dir_a2b ? a_in : b_in;
    assign op      = pick_op(par_mode, async_load, src_ok);
    assign b_drive = dir_a2b;
    assign a_drive = !dir_a2b && a_en;
endmodule

// File: rtl/stage_chain.sv
module stage_chain
    import duplex_bus_shreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  op_e          op,
    input  logic [W-1:0] src,
    input  logic         ser_in,
    output logic [W-1:0] stored,
    output logic [W-1:0] view
);
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic shift_src;
        if (i == 0) begin : g_head
            assign shift_src = ser_in;
        end else begin : g_body
            assign shift_src = stored[i-1];
        end

        always_comb begin
            unique case (op)
                OP_SHIFT:                 nxt[i] = shift_src;
                OP_LOAD_CLK, OP_LOAD_LVL: nxt[i] = src[i];
                default:                  nxt[i] = stored[i];
            endcase
        end

        // The level-sensitive load shows the source bus at once; the flop
        // keeps whatever was present at each edge inside the window.
        assign view[i] = (op == OP_LOAD_LVL) ? src[i] : stored[i];
    end

    always_ff @(posedge clk) begin
        if (rst) stored <= '0;
        else     stored <= nxt;
    end

    // R7: serial shift moves the chain by exactly one place per edge
    p_shift_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (stored == {$past(stored[W-2:0]), $past(ser_in)}));
endmodule

// File: rtl/port_mux.sv
module port_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] view,
    input  logic         a_drive,
    input  logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         ser_out
);
    assign a_oe    = a_drive;
    assign b_oe    = b_drive;
    assign a_out   = a_drive ? view : '0;
    assign b_out   = b_drive ? view : '0;
    assign ser_out = view[W-1];
endmodule

// File: rtl/duplex_bus_shreg.sv
module duplex_bus_shreg
    import duplex_bus_shreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         a_en,
    input  logic         dir_a2b,
    input  logic         par_mode,
    input  logic         async_load,
    input  logic         ser_in,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         ser_out
);
    op_e          op;
    logic [W-1:0] src;
    logic [W-1:0] stored;
    logic [W-1:0] view;
    logic         a_drive;
    logic         b_drive;

    bus_ctl_decode #(.W(W)) u_decode (
        .par_mode  (par_mode),
        .async_load(async_load),
        .dir_a2b   (dir_a2b),
        .a_en      (a_en),
        .a_in      (a_in),
        .b_in      (b_in),
        .op        (op),
        .src       (src),
        .a_drive   (a_drive),
        .b_drive   (b_drive)
    );

    stage_chain #(.W(W)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .src   (src),
        .ser_in(ser_in),
        .stored(stored),
        .view  (view)
    );

    port_mux #(.W(W)) u_ports (
        .view   (view),
        .a_drive(a_drive),
        .b_drive(b_drive),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_out  (b_out),
        .b_oe   (b_oe),
        .ser_out(ser_out)
    );

    // R2: both buses are never driven together
    p_oe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));

    // R8: a parallel request from a disabled A bus leaves the stages alone
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (par_mode && dir_a2b && !a_en) |=> (stored == $past(stored)));

    // R4: a clocked load from A stores the A pins
    p_clk_load_r4: assert property (@(posedge clk) disable iff (rst)
        (par_mode && !async_load && dir_a2b && a_en) |=> (stored == $past(a_in)));

    // R6: level-sensitive load from B shows B on A with no edge needed
    p_lvl_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (par_mode && async_load && !dir_a2b && a_en) |-> (a_out == b_in));
endmodule

// File: tb/duplex_bus_shreg_tb.sv
module duplex_bus_shreg_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst, a_en, dir_a2b, par_mode, async_load, ser_in;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe, ser_out;

    always #5 clk = ~clk;

    duplex_bus_shreg #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .a_en(a_en), .dir_a2b(dir_a2b),
        .par_mode(par_mode), .async_load(async_load), .ser_in(ser_in),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
    );

    typedef struct packed {
        logic [W-1:0] a_out;
        logic         a_oe;
        logic [W-1:0] b_out;
        logic         b_oe;
        logic         ser_out;
    } obs_t;

    obs_t         exp_fifo[$];
    string        tag_fifo[$];
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 0;
    logic [W-1:0] m_q = '0;
    obs_t         got;

    assign got = {a_out, a_oe, b_out, b_oe, ser_out};

    // Bench model of the port view, from the requirements.
    function automatic obs_t predict();
        obs_t         o;
        logic         ok;
        logic [W-1:0] v;
        ok        = dir_a2b ? a_en : 1'b1;
        v         = (par_mode && async_load && ok) ? (dir_a2b ? a_in : b_in) : m_q;
        o.b_oe    = dir_a2b;
        o.a_oe    = !dir_a2b && a_en;
        o.a_out   = o.a_oe ? v : '0;
        o.b_out   = o.b_oe ? v : '0;
        o.ser_out = v[W-1];
        return o;
    endfunction

    task automatic compare(input string tag, input obs_t g, input obs_t e);
        n_cmp++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL %s: got a_out=%h a_oe=%b b_out=%h b_oe=%b ser=%b expected a_out=%h a_oe=%b b_out=%h b_oe=%b ser=%b",
                     tag, g.a_out, g.a_oe, g.b_out, g.b_oe, g.ser_out,
                     e.a_out, e.a_oe, e.b_out, e.b_oe, e.ser_out);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected view.
    task automatic step(input logic r, input logic p, input logic as, input logic d,
                        input logic ae, input logic s, input logic [W-1:0] ai,
                        input logic [W-1:0] bi, input string tag);
        @(negedge clk);
        rst = r; par_mode = p; async_load = as; dir_a2b = d; a_en = ae;
        ser_in = s; a_in = ai; b_in = bi;
        if (r)                 m_q = '0;
        else if (!p)           m_q = {m_q[W-2:0], s};
        else if (d ? ae : 1'b1) m_q = d ? ai : bi;
        exp_fifo.push_back(predict());
        tag_fifo.push_back(tag);
    endtask

    // Mid-cycle change of B during a level-sensitive load, restored before the edge.
    task automatic lvl_peek(input logic [W-1:0] nb, input string tag);
        logic [W-1:0] keep;
        keep = b_in;
        #1 b_in = nb;
        #1 compare(tag, got, predict());
        b_in = keep;
        #1 compare(tag, got, predict());
    endtask

    // Monitor: compares queued expectations just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (exp_fifo.size() > 0)
                compare(tag_fifo.pop_front(), got, exp_fifo.pop_front());
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; a_en = 0; dir_a2b = 0; par_mode = 0; async_load = 0;
        ser_in = 0; a_in = '0; b_in = '0;

        // R1: reset state
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R1 reset");
        step(1, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R1 reset B view");

        // R4: clocked load from A, shown on B
        step(0, 1, 0, 1, 1, 0, 8'hA5, 8'h3C, "R4 clocked A load");
        step(0, 1, 0, 1, 1, 0, 8'h5E, 8'hFF, "R4 second A load");

        // R5: clocked load from B, shown on A; also with a_en=0
        step(0, 1, 0, 0, 1, 0, 8'h11, 8'h5A, "R5 clocked B load");
        step(0, 1, 0, 0, 0, 0, 8'h22, 8'hC7, "R5/R3 B load with A disabled");
        step(0, 1, 0, 0, 1, 0, 8'h22, 8'hC7, "R9 A shows stored word");

        // R8: A as source but disabled, clocked and level-sensitive
        step(0, 1, 0, 1, 0, 0, 8'h99, 8'h00, "R8 clocked hold");
        step(0, 1, 1, 1, 0, 1, 8'h66, 8'h00, "R8 level hold");

        // R1: reset clears a loaded word
        step(1, 1, 0, 1, 1, 0, 8'hF0, 8'h00, "R1 reset over load");
        step(0, 1, 0, 1, 0, 0, 8'hF0, 8'h00, "R1 cleared kept");

        // R7: serial shift with async_load toggling
        foreach (m_q[k]) begin
            step(0, 0, k[0], 1, k[1], (8'hB2 >> k) & 1'b1, 8'h77, 8'h88, "R7 shift");
        end
        step(0, 0, 1, 0, 1, 1, 8'h00, 8'h00, "R7 shift seen on A");

        // R6: level-sensitive load follows B without an edge, then retains
        step(0, 1, 1, 0, 1, 0, 8'h00, 8'hC3, "R6 level load");
        lvl_peek(8'h96, "R6 follows B mid-cycle");
        step(0, 1, 1, 0, 1, 0, 8'h00, 8'h4D, "R6 level load new");
        lvl_peek(8'h01, "R6 follows B again");
        step(0, 1, 0, 1, 0, 0, 8'hEE, 8'h00, "R6 retained after exit");
        step(0, 1, 1, 1, 1, 0, 8'h7B, 8'h00, "R6 level load from A");

        // R2/R9: every combination of the four mode controls
        for (int c = 0; c < 16; c++) begin
            step(0, c[3], c[2], c[1], c[0], c[0] ^ c[2],
                 8'(8'h1F + c * 13), 8'(8'hE1 - c * 7), "R2/R9 control sweep");
        end
        step(0, 1, 0, 1, 0, 0, 8'h00, 8'h00, "R2 sweep end");

        @(posedge clk);
        #3;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule